// File: doc/BRIEF.md
# Compare Flag and Condition Unit

This unit compares two integer operands by forming the first minus the second, without ever returning the difference. From that subtraction it derives four status flags: carry (borrow), zero, sign and overflow. A strobe loads them into a register. A condition selector then reads the registered flags and reports whether an equality, unsigned ordering or signed ordering condition holds. A branch or conditional-select stage can use that result directly.

The second operand is either a full-width register value or a narrower immediate. The immediate is sign-extended before the subtraction. An operand-width select chooses an 8, 16, 32 or 64-bit comparison. All flags come from the most significant bit of the chosen width, and operand bits above that width have no effect.

Top module: `cmp_flag_unit`

## Requirements
- R1: After a capture, carryFlag is 1 exactly when the first operand, read unsigned at the selected width, is below the second operand.
- R2: After a capture, zeroFlag is 1 exactly when the two operands are equal at the selected width. When zeroFlag is 1, carryFlag, signFlag and ovfFlag are all 0.
- R3: After a capture, signFlag equals the top bit of (first minus second) at the selected width.
- R4: After a capture, ovfFlag is 1 exactly when the signed subtraction overflows at the selected width. Equivalently, signFlag differs from ovfFlag exactly when the first operand is signed-less than the second.
- R5: When useImm is 1, the second operand is the 32-bit imm, sign-extended to the selected width, and opB is ignored.
- R6: widthSel encodes the width as 0=8, 1=16, 2=32, 3=64 bits. Operand bits above the selected width do not affect any flag.
- R7: Flags load on the clock edge where valid is 1. With valid at 0 they hold, whatever the operand inputs do.
- R8: condTrue is evaluated combinationally from the registered flags. condSel codes: 0 equal, 1 not equal, 2 unsigned below, 3 unsigned below-or-equal, 4 unsigned above, 5 unsigned above-or-equal, 6 signed less, 7 signed less-or-equal, 8 signed greater, 9 signed greater-or-equal. Codes 10 to 15 give 0.
- R9: While rstN is low, and after it rises until the first capture, all four flags are 0.
- R10: A 32-bit compare of 2 against 5 gives zero 0, sign 1, overflow 0 and carry 1. A compare of 5 against 2 gives all four flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Capture strobe for the flags |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand when useImm is 0 |
| imm | input | 32 | Immediate second operand, sign-extended |
| useImm | input | 1 | Selects imm instead of opB |
| widthSel | input | 2 | Comparison width: 0=8, 1=16, 2=32, 3=64 bits |
| condSel | input | 4 | Condition code evaluated on the registered flags |
| carryFlag | output | 1 | Registered borrow flag |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |
| ovfFlag | output | 1 | Registered signed-overflow flag |
| condTrue | output | 1 | Selected condition holds |

## Verification
The hardest flags to reach are overflow and the signed conditions near the extreme values. Random operands seldom produce a subtraction that wraps past the most-negative or most-positive value at the narrow widths. The stimulus therefore pairs the minimum and maximum signed values of every width with each other and with small values. It also places random garbage above the selected width, to show that those bits are ignored. Negative immediates are used at each width, because only then does the sign extension change the result.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [1:0] {
    WIDTH_8  = 2'd0,
    WIDTH_16 = 2'd1,
    WIDTH_32 = 2'd2,
    WIDTH_64 = 2'd3
  } width_e;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_ULT = 4'd2,
    CC_ULE = 4'd3,
    CC_UGT = 4'd4,
    CC_UGE = 4'd5,
    CC_SLT = 4'd6,
    CC_SLE = 4'd7,
    CC_SGT = 4'd8,
    CC_SGE = 4'd9
  } cond_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic ovf;
  } flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic pickImm;
  } strobes_t;

endpackage

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        widthSel,
  output flags_t            flagsQ
);

  localparam int NUM_WIDTHS = 4;
  localparam int EXT_W      = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] srcB;
  flags_t            laneFlags [NUM_WIDTHS];
  flags_t            flagsD;

  assign immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign srcB   = strb.pickImm ? immExt : opB;

  // one subtract lane per supported width; flags come from each lane's top bit
  for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_WIDTHS - 1 - i);
    logic [LW:0] diffExt;
    logic        ovfLane;

    assign diffExt = {1'b0, opA[LW-1:0]} - {1'b0, srcB[LW-1:0]};
    assign ovfLane = (opA[LW-1] ^ srcB[LW-1]) & (diffExt[LW-1] ^ opA[LW-1]);
    assign laneFlags[i] = {diffExt[LW], (diffExt[LW-1:0] == '0), diffExt[LW-1], ovfLane};
  end

  assign flagsD = laneFlags[widthSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (strb.capture) begin
      flagsQ <= flagsD;
    end
  end

endmodule

// File: rtl/cmp_control.sv
module cmp_control
  import cmp_pkg::*;
(
  input  logic       valid,
  input  logic       useImm,
  input  logic [3:0] condSel,
  input  flags_t     flagsQ,
  output strobes_t   strb,
  output logic       condTrue
);

  logic signedLess;

  assign strb.capture = valid;
  assign strb.pickImm = useImm;

  assign signedLess = flagsQ.sign ^ flagsQ.ovf;

  always_comb begin
    unique case (condSel)
      CC_EQ:   condTrue = flagsQ.zero;
      CC_NE:   condTrue = !flagsQ.zero;
      CC_ULT:  condTrue = flagsQ.carry;
      CC_ULE:  condTrue = flagsQ.carry | flagsQ.zero;
      CC_UGT:  condTrue = !flagsQ.carry & !flagsQ.zero;
      CC_UGE:  condTrue = !flagsQ.carry;
      CC_SLT:  condTrue = signedLess;
      CC_SLE:  condTrue = signedLess | flagsQ.zero;
      CC_SGT:  condTrue = !signedLess & !flagsQ.zero;
      CC_SGE:  condTrue = !signedLess;
      default: condTrue = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [31:0] imm,
  input  logic        useImm,
  input  logic [1:0]  widthSel,
  input  logic [3:0]  condSel,
  output logic        carryFlag,
  output logic        zeroFlag,
  output logic        signFlag,
  output logic        ovfFlag,
  output logic        condTrue
);

  strobes_t strb;
  flags_t   flagsQ;

  cmp_control u_control (
    .valid    (valid),
    .useImm   (useImm),
    .condSel  (condSel),
    .flagsQ   (flagsQ),
    .strb     (strb),
    .condTrue (condTrue)
  );

  cmp_datapath #(
    .DATA_W (64),
    .IMM_W  (32)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .widthSel (widthSel),
    .flagsQ   (flagsQ)
  );

  assign carryFlag = flagsQ.carry;
  assign zeroFlag  = flagsQ.zero;
  assign signFlag  = flagsQ.sign;
  assign ovfFlag   = flagsQ.ovf;

endmodule

// File: rtl/cmp_flag_unit_checker.sv
module cmp_flag_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        valid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [31:0] imm,
  input logic        useImm,
  input logic [1:0]  widthSel,
  input logic [3:0]  condSel,
  input logic        carryFlag,
  input logic        zeroFlag,
  input logic        signFlag,
  input logic        ovfFlag,
  input logic        condTrue
);

  assert_unsigned_below_R1: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !useImm && widthSel == 2'd3) |=> (carryFlag == ($past(opA) < $past(opB))));

  assert_equal_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag |-> (!carryFlag && !signFlag && !ovfFlag));

  assert_signed_less_R4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !useImm && widthSel == 2'd3)
      |=> ((signFlag != ovfFlag) == ($signed($past(opA)) < $signed($past(opB)))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> ($stable(carryFlag) && $stable(zeroFlag) && $stable(signFlag) && $stable(ovfFlag)));

  assert_cond_eq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'd0) |-> (condTrue == zeroFlag));

  assert_cond_sgt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 4'd8) |-> (condTrue == (!zeroFlag && (signFlag == ovfFlag))));

  assert_cond_spare_R8: assert property (@(posedge clk) disable iff (!rstN)
    (condSel >= 4'd10) |-> !condTrue);

endmodule

bind cmp_flag_unit cmp_flag_unit_checker u_chk (.*);

// File: tb/cmp_flag_unit_tb.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        valid;
  logic [63:0] opA, opB;
  logic [31:0] imm;
  logic        useImm;
  logic [1:0]  widthSel;
  logic [3:0]  condSel;
  logic        carryFlag, zeroFlag, signFlag, ovfFlag, condTrue;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cmp_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .opA(opA), .opB(opB), .imm(imm),
    .useImm(useImm), .widthSel(widthSel), .condSel(condSel),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .ovfFlag(ovfFlag), .condTrue(condTrue)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: masks, integer compares, no subtract-lane structure
  bit refC, refZ, refS, refO, refUlt, refSlt, refEq;

  task automatic refModel(input logic [63:0] a, input logic [63:0] b, input int w);
    longint unsigned mask, ua, ub, d;
    longint sa, sb;
    mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    ua = a & mask;
    ub = b & mask;
    sa = $signed(ua << (64 - w)) >>> (64 - w);
    sb = $signed(ub << (64 - w)) >>> (64 - w);
    d  = (ua - ub) & mask;
    refUlt = (ua < ub);
    refEq  = (ua == ub);
    refSlt = (sa < sb);
    refC = refUlt;
    refZ = refEq;
    refS = d[w-1];
    refO = refSlt ^ refS;
  endtask

  function automatic bit condExp(input int code);
    case (code)
      0: return refEq;
      1: return !refEq;
      2: return refUlt;
      3: return refUlt || refEq;
      4: return !refUlt && !refEq;
      5: return !refUlt;
      6: return refSlt;
      7: return refSlt || refEq;
      8: return !refSlt && !refEq;
      9: return !refSlt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runVec(input logic [63:0] a, input logic [63:0] b, input logic [31:0] im,
                        input bit selImm, input int ws, input string tag);
    logic [63:0] effB;
    int w;
    w = 8 << ws;
    effB = selImm ? {{32{im[31]}}, im} : b;
    refModel(a, effB, w);
    @(negedge clk);
    opA = a; opB = b; imm = im; useImm = selImm; widthSel = 2'(ws); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    opA = ~a; opB = ~b; imm = ~im; useImm = !selImm;   // must be ignored while not capturing
    chk({tag, " R1 carry"}, 64'(carryFlag), 64'(refC));
    chk({tag, " R2 zero"},  64'(zeroFlag),  64'(refZ));
    chk({tag, " R3 sign"},  64'(signFlag),  64'(refS));
    chk({tag, " R4 ovf"},   64'(ovfFlag),   64'(refO));
    if (selImm) chk({tag, " R5 imm flags"}, 64'({carryFlag, zeroFlag, signFlag, ovfFlag}),
                    64'({refC, refZ, refS, refO}));
    for (int c = 0; c < 12; c++) begin
      condSel = 4'(c);
      #1;
      chk($sformatf("%s R8 cond=%0d", tag, c), 64'(condTrue), 64'(condExp(c)));
    end
    @(negedge clk);
    chk({tag, " R7 hold"}, 64'({carryFlag, zeroFlag, signFlag, ovfFlag}),
        64'({refC, refZ, refS, refO}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] minV, maxV, junk;
    rstN = 1'b0; valid = 1'b0; opA = '0; opB = '0; imm = '0;
    useImm = 1'b0; widthSel = 2'd3; condSel = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset flags", 64'({carryFlag, zeroFlag, signFlag, ovfFlag}), 64'h0);
    // valid while in reset must not load
    opA = 64'd1; opB = 64'd2; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 after release", 64'({carryFlag, zeroFlag, signFlag, ovfFlag}), 64'h0);

    // worked examples
    runVec(64'd2, 64'd5, 32'd0, 1'b0, 2, "ex2v5");
    chk("R10 2v5 {c,z,s,o}", 64'({carryFlag, zeroFlag, signFlag, ovfFlag}), 64'b1010);
    runVec(64'd5, 64'd2, 32'd0, 1'b0, 2, "ex5v2");
    chk("R10 5v2 {c,z,s,o}", 64'({carryFlag, zeroFlag, signFlag, ovfFlag}), 64'b0000);

    // extreme signed values at each width, with garbage above the width
    for (int ws = 0; ws < 4; ws++) begin
      int w;
      w = 8 << ws;
      minV = 64'd1 << (w - 1);
      maxV = minV - 64'd1;
      junk = (ws == 3) ? 64'd0 : ({$urandom, $urandom} << w);
      runVec(minV | junk, maxV, 32'd0, 1'b0, ws, "R6 min-max");
      runVec(maxV, minV | junk, 32'd0, 1'b0, ws, "R6 max-min");
      runVec(minV, 64'd1, 32'd0, 1'b0, ws, "R4 min-1");
      runVec(maxV, ~64'd0, 32'd0, 1'b0, ws, "R4 max-neg1");
      runVec(minV | junk, minV, 32'd0, 1'b0, ws, "R2 equal");
      runVec(64'd0, 64'd0, 32'hFFFF_FFFF, 1'b1, ws, "R5 zero-vs-neg1");
      runVec(minV, 64'd0, 32'h8000_0000, 1'b1, ws, "R5 min-vs-immmin");
      runVec(maxV | junk, 64'd7, 32'h7FFF_FFFF, 1'b1, ws, "R5 max-vs-immmax");
    end

    // random operands at all widths, both operand sources
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (n % 5 == 0) ? a : {$urandom, $urandom};
      runVec(a, b, $urandom, 1'((n / 4) % 2), n % 4, "R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule